// File: doc/BRIEF.md
# Wake Event Latch Unit

This block gathers wake events for a power controller. It watches two independent banks of event lines: one bank carries signals from on-chip interrupt sources and the other carries external pins. Each line first passes through a synchronizer. An edge detector then compares the synchronized level with the level one cycle earlier. When the edge matches the active direction chosen for that bit, the event is held in a sticky status bit. Software clears a held bit by writing a one to it.

Each bank has a per-bit enable that gates the sticky bits into a masked view. A single registered wake request goes high whenever any enabled, held event exists in either bank. Software reaches all eight registers through a plain single-cycle register port. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `wake_latch_unit`

## Requirements
- R1: After reset, every enable bit and every sticky status bit is 0 and the wake request is low. Each bank's edge-select register resets to its parameter value, which defaults to all zeros (falling-edge activation for every bit).
- R2: Register address bit 2 selects the bank (0 internal sources, 1 pins). Address bits 1:0 select the register: 0 is the enable (read/write), 1 is the edge select (read/write), 2 is the sticky status (read, write-one-to-clear) and 3 is the masked status (read only).
- R3: An edge-select bit of 1 makes that event line latch on a low-to-high transition, and 0 makes it latch on a high-to-low transition. A transition in the other direction sets nothing.
- R4: Writing 1 to a sticky status bit clears it, and writing 0 leaves it unchanged. Writing back the value just read clears every event that was read.
- R5: Sticky status bits latch qualifying edges whether or not the matching enable bit is set.
- R6: Masked status reads as the sticky status ANDed with the enable register of the same bank.
- R7: When a clear write and a new qualifying edge hit the same bit in the same cycle, the bit remains set.
- R8: The wake request is a register that holds, one cycle later, the OR of all masked status bits of both banks.
- R9: An input change applied before clock edge n appears in the sticky status after clock edge n+2 and not earlier.
- R10: A write to one bank leaves the other bank's registers unchanged. Writes to the masked status address are ignored.
- R11: A line held at its active level after a clear does not latch again until a new qualifying transition occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_evt_i | input | EVT_W | Event lines from internal sources (asynchronous) |
| pin_evt_i | input | EVT_W | Event lines from external pins (asynchronous) |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: bit 2 bank, bits 1:0 register |
| reg_wdata_i | input | EVT_W | Register write data |
| reg_rdata_o | output | EVT_W | Read data for the addressed register |
| wake_req_o | output | 1 | Registered wake request |

## Verification
An input transition driven before clock edge n reaches the sticky status after edge n+2, the masked status in that same cycle, and the wake request after edge n+3. Register writes show up in read data right after their own edge, and the wake request follows them one edge later. The reference model in the bench keeps a three-deep history of sampled input levels and advances its registers on every clock edge. All outputs are sampled on the falling edge, so each directed check waits exactly the number of edges listed above before it reads the port.

// File: rtl/wlu_pkg.sv
package wlu_pkg;

    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 3;

    typedef enum logic [1:0] {
        FLD_ENABLE   = 2'd0,
        FLD_EDGE_SEL = 2'd1,
        FLD_STICKY   = 2'd2,
        FLD_MASKED   = 2'd3
    } wlu_field_e;

endpackage

// File: rtl/wlu_edge.sv
module wlu_edge #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] hit_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] sync;
        logic [W-1:0]             prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [W-1:0] cur;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = lvl_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur   = st_q.sync[STAGES-1];
    assign hit_o = (rise_sel_i & cur & ~st_q.prev) | (~rise_sel_i & ~cur & st_q.prev);

    AST_NO_REPEAT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != '0) |=> ((hit_o & $past(hit_o) & ~(rise_sel_i ^ $past(rise_sel_i))) == '0)); // R11

endmodule

// File: rtl/wlu_bank.sv
module wlu_bank
    import wlu_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] SEL_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         wr_en_i,
    input  wlu_field_e   fld_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] masked_o
);

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] sel;
        logic [W-1:0] sticky;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] hit;
    logic [W-1:0] clr;

    wlu_edge #(.W(W), .STAGES(STAGES)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (evt_i),
        .rise_sel_i(st_q.sel),
        .hit_o     (hit)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_en_i) begin
            unique case (fld_i)
                FLD_ENABLE:   st_d.en  = wdata_i;
                FLD_EDGE_SEL: st_d.sel = wdata_i;
                FLD_STICKY:   clr      = wdata_i;
                default:      ;
            endcase
        end
        st_d.sticky = (st_q.sticky & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en     <= '0;
            st_q.sel    <= SEL_RST;
            st_q.sticky <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign masked_o = st_q.sticky & st_q.en;

    always_comb begin
        unique case (fld_i)
            FLD_ENABLE:   rdata_o = st_q.en;
            FLD_EDGE_SEL: rdata_o = st_q.sel;
            FLD_STICKY:   rdata_o = st_q.sticky;
            default:      rdata_o = masked_o;
        endcase
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && fld_i == FLD_STICKY && (wdata_i & ~hit) != '0)
        |=> ((st_q.sticky & $past(wdata_i & ~hit)) == '0)); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((st_q.sticky & $past(hit)) == $past(hit))); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sticky & ~$past(st_q.sticky) & ~$past(hit)) == '0)); // R3
    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.en)); // R10

endmodule

// File: rtl/wake_latch_unit.sv
module wake_latch_unit
    import wlu_pkg::*;
#(
    parameter int               EVT_W       = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [EVT_W-1:0] INT_SEL_RST = '0,
    parameter logic [EVT_W-1:0] PIN_SEL_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  int_evt_i,
    input  logic [EVT_W-1:0]  pin_evt_i,
    input  logic              reg_wr_en_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [EVT_W-1:0]  reg_wdata_i,
    output logic [EVT_W-1:0]  reg_rdata_o,
    output logic              wake_req_o
);

    typedef struct packed {
        logic wake;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_BANKS-1:0][EVT_W-1:0] bank_evt;
    logic [NUM_BANKS-1:0][EVT_W-1:0] bank_rdata;
    logic [NUM_BANKS-1:0][EVT_W-1:0] bank_masked;
    wlu_field_e                      fld;
    logic                            any_masked;

    assign bank_evt[0] = int_evt_i;
    assign bank_evt[1] = pin_evt_i;
    assign fld         = wlu_field_e'(reg_addr_i[1:0]);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [EVT_W-1:0] SEL_INIT = (g == 0) ? INT_SEL_RST : PIN_SEL_RST;
        logic bank_wr;
        assign bank_wr = reg_wr_en_i && (reg_addr_i[2] == g[0]);

        wlu_bank #(.W(EVT_W), .STAGES(SYNC_STAGES), .SEL_RST(SEL_INIT)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (bank_evt[g]),
            .wr_en_i (bank_wr),
            .fld_i   (fld),
            .wdata_i (reg_wdata_i),
            .rdata_o (bank_rdata[g]),
            .masked_o(bank_masked[g])
        );
    end

    assign reg_rdata_o = bank_rdata[reg_addr_i[2]];

    always_comb begin
        any_masked = 1'b0;
        for (int g = 0; g < NUM_BANKS; g++) begin
            any_masked = any_masked | (|bank_masked[g]);
        end
        st_d      = st_q;
        st_d.wake = any_masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_req_o = st_q.wake;

    AST_WAKE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_masked[0] | bank_masked[1]) != '0) |=> wake_req_o); // R8
    AST_WAKE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_masked[0] | bank_masked[1]) == '0) |=> !wake_req_o); // R8
    AST_READ_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 3'd7) |-> ((reg_rdata_o & ~bank_masked[1]) == '0)); // R6

endmodule

// File: tb/wake_latch_unit_tb.sv
module wake_latch_unit_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] int_evt = '0;
    logic [W-1:0] pin_evt = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         wake;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    wake_latch_unit #(.EVT_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_evt_i  (int_evt),
        .pin_evt_i  (pin_evt),
        .reg_wr_en_i(wr_en),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .wake_req_o (wake)
    );

    // behavioural reference
    logic [W-1:0] m_en [2];
    logic [W-1:0] m_sel [2];
    logic [W-1:0] m_stk [2];
    logic         m_wake;
    logic [W-1:0] hq0[$];
    logic [W-1:0] hq1[$];

    function automatic logic [W-1:0] hit_of(logic [W-1:0] sel, logic [W-1:0] n1, logic [W-1:0] n2);
        return (sel & n1 & ~n2) | (~sel & ~n1 & n2);
    endfunction

    function automatic logic [W-1:0] mread(logic [2:0] a);
        int g = a[2] ? 1 : 0;
        case (a[1:0])
            2'd0:    return m_en[g];
            2'd1:    return m_sel[g];
            2'd2:    return m_stk[g];
            default: return m_stk[g] & m_en[g];
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [W-1:0] h0, h1, c0, c1;
        logic         nw;
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin
                m_en[g] = '0; m_sel[g] = '0; m_stk[g] = '0;
            end
            m_wake = 1'b0;
            hq0 = '{'0, '0, '0};
            hq1 = '{'0, '0, '0};
        end else begin
            h0 = hit_of(m_sel[0], hq0[1], hq0[2]);
            h1 = hit_of(m_sel[1], hq1[1], hq1[2]);
            nw = ((m_stk[0] & m_en[0]) != '0) || ((m_stk[1] & m_en[1]) != '0);
            c0 = (wr_en && addr == 3'd2) ? wdata : '0;
            c1 = (wr_en && addr == 3'd6) ? wdata : '0;
            if (wr_en) begin
                case (addr)
                    3'd0: m_en[0]  = wdata;
                    3'd1: m_sel[0] = wdata;
                    3'd4: m_en[1]  = wdata;
                    3'd5: m_sel[1] = wdata;
                    default: ;
                endcase
            end
            m_stk[0] = (m_stk[0] & ~c0) | h0;
            m_stk[1] = (m_stk[1] & ~c1) | h1;
            m_wake = nw;
            hq0.push_front(int_evt); void'(hq0.pop_back());
            hq1.push_front(pin_evt); void'(hq1.pop_back());
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8 wake vs model", {31'd0, wake}, {31'd0, m_wake});
            chk("R2 rdata vs model", rdata, mread(addr));
        end
    end

    task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        idle(4);
        rst_n = 1'b1;
        // R1 reset values on all addresses
        for (int a = 0; a < 8; a++) rd(a[2:0], '0, "R1 reset value");
        chk("R1 wake low", {31'd0, wake}, '0);

        // R3 rising ignored with falling select
        pin_evt[3] = 1'b1;
        idle(4);
        rd(3'd6, '0, "R3 opposite edge ignored");
        // R9 latency of a falling edge
        pin_evt[3] = 1'b0;
        idle(2);
        rd(3'd6, '0, "R9 not yet latched");
        idle(1);
        rd(3'd6, 32'h8, "R9 latched at n+2");
        rd(3'd7, '0, "R6 masked with enable off");
        chk("R5 latched while disabled, no wake", {31'd0, wake}, '0);

        wr(3'd4, 32'h8);
        rd(3'd7, 32'h8, "R6 masked follows enable");
        chk("R8 wake one edge later", {31'd0, wake}, '0);
        idle(1);
        chk("R8 wake raised", {31'd0, wake}, 1);

        wr(3'd6, 32'h0);
        rd(3'd6, 32'h8, "R4 zero write no effect");
        wr(3'd6, 32'h8);
        rd(3'd6, '0, "R4 write-back clears");
        idle(1);
        chk("R8 wake dropped", {31'd0, wake}, '0);
        idle(5);
        rd(3'd6, '0, "R11 held level no relatch");

        // internal bank, rising select
        wr(3'd1, 32'h20);
        int_evt[5] = 1'b1;
        idle(4);
        rd(3'd2, 32'h20, "R3 rising latched");
        rd(3'd6, '0, "R10 pin bank untouched");
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, '0, "R10 masked write ignored");
        rd(3'd0, '0, "R10 enable unchanged by masked write");
        wr(3'd0, 32'h20);
        rd(3'd4, 32'h8, "R10 pin enable kept");
        idle(1);
        chk("R8 wake from internal bank", {31'd0, wake}, 1);

        // R7 clear and edge collide
        int_evt[5] = 1'b0;
        idle(4);
        rd(3'd2, 32'h20, "R3 falling ignored with rising select");
        int_evt[5] = 1'b1;
        idle(2);
        wr(3'd2, 32'h20);
        rd(3'd2, 32'h20, "R7 edge wins over clear");
        wr(3'd2, 32'h20);
        rd(3'd2, '0, "R4 clear after collision");

        // mixed traffic checked against the model every cycle
        wr(3'd5, 32'hA5A5_0F0F);
        wr(3'd4, 32'h00FF_FF00);
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pin_evt = pin_evt ^ (lfsr & {lfsr[7:0], lfsr[31:8]} & 32'h1111_1111);
            int_evt = int_evt ^ (lfsr & 32'h0808_0404);
            if (lfsr[3:0] == 4'h5) wr(3'd6, lfsr ^ 32'h5A5A_5A5A);
            else if (lfsr[3:0] == 4'h9) wr(3'd2, lfsr);
            else begin
                addr = lfsr[6:4];
                idle(1);
            end
        end
        rd(3'd6, mread(3'd6), "R4 final sticky");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule